// File: doc/BRIEF.md
# Bidirectional Latch/Register Bus Transceiver

The block moves a W-bit word (18 by default) between an A side and a B side. The A-to-B path and the B-to-A path are independent. Each path has one storage stage per bit and its own four controls: a drive enable (active low), a latch enable, a port clock and a clock enable (active low).

With the latch enable high, the stage is transparent and passes its input through. With the latch enable low, the stage holds its value. It loads a new word only on a falling edge of the port clock, and only while the clock enable is low.

The model is fully synchronous to one fast system clock. The port clocks and controls are ordinary inputs sampled on that clock, and a falling edge is found by comparing the current sample with the previous one. Tri-state is shown as split signals per side: `*_in`, `*_out` and an active-low drive flag. An outer pad ring turns these into real bidirectional pins.

Top module: `dual_path_xcvr`

## Requirements
- R1: A system-clock edge with `rst` high clears both storage stages to zero. On the following cycle `a_out` and `b_out` are 0 and `a_drv_n` and `b_drv_n` are 1 (not driving).
- R2: When a path's latch enable is 1 at a system-clock edge, that path's output after the edge equals the path input sampled at that edge (transparent mode, one system-clock of latency).
- R3: When the latch enable is 0 and no qualifying falling edge is seen at a system-clock edge, the output is unchanged. This holds when the port clock stays high and when it stays low.
- R4: When the latch enable is 0 and the clock enable is 0, a qualifying falling edge is seen at a system-clock edge where the port clock sampled 1 at the previous edge and 0 at this edge. On such an edge the input sampled at this edge is stored and output.
- R5: When the clock enable is 1, a falling port-clock edge with the latch enable at 0 leaves the output unchanged.
- R6: After each system-clock edge outside reset, a path's drive flag equals its drive-enable input sampled at that edge. Storage updates under R2 and R4 still take place while the drive flag is 1.
- R7: When the latch enable goes from 1 to 0 with a static port clock, the output keeps the last word passed while it was transparent.
- R8: The two paths are independent: controls and input of one path never change the output or drive flag of the other.
- R9: A rising edge of the port clock (sampled 0, then 1) with the latch enable at 0 does not load the stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; every storage element changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | W | Word arriving on the A side (source of the A-to-B path) |
| a_out | output | W | Word the B-to-A path presents to the A side |
| a_drv_n | output | 1 | Active-low drive flag for the A side; 1 means high impedance |
| b_in | input | W | Word arriving on the B side (source of the B-to-A path) |
| b_out | output | W | Word the A-to-B path presents to the B side |
| b_drv_n | output | 1 | Active-low drive flag for the B side; 1 means high impedance |
| ab_en_n | input | 1 | Drive enable for the A-to-B path, active low |
| ab_le | input | 1 | Latch enable for the A-to-B path, 1 = transparent |
| ab_pclk | input | 1 | Port clock for the A-to-B path; falling edge loads |
| ab_cke_n | input | 1 | Clock enable for the A-to-B path, active low |
| ba_en_n | input | 1 | Drive enable for the B-to-A path, active low |
| ba_le | input | 1 | Latch enable for the B-to-A path, 1 = transparent |
| ba_pclk | input | 1 | Port clock for the B-to-A path; falling edge loads |
| ba_cke_n | input | 1 | Clock enable for the B-to-A path, active low |

## Verification
Within one system cycle a path can both load a word and change its drive flag. The bench sweeps every combination of the four controls on both paths, so loads happen with the drive flag both high and low. It expects the stored word to update either way and the drive flag to track its enable on its own. Two further events share cycles: a falling port-clock edge arriving together with the latch enable, and the same edge arriving together with the clock enable. The bench compares both against a model built from the requirements. Cycles where both paths are enabled at once are reported as usage conflicts, and their data is not judged.

// File: rtl/dpx_pkg.sv
package dpx_pkg;
   typedef struct packed {
      logic en_n;
      logic le;
      logic pclk;
      logic cke_n;
   } dpx_ctl_t;

   localparam int DPX_NDIR = 2;
endpackage

// File: rtl/dpx_ctl_in.sv
module dpx_ctl_in
   import dpx_pkg::*;
#(
   parameter int W    = 18,
   parameter int SYNC = 0
) (
   input  logic           clk,
   input  dpx_ctl_t       raw_ctl,
   input  logic [W-1:0]   raw_dat,
   output dpx_ctl_t       cur_ctl,
   output logic [W-1:0]   cur_dat,
   output logic           pclk_d
);
   generate
      if (SYNC == 0) begin : g_direct
         assign cur_ctl = raw_ctl;
         assign cur_dat = raw_dat;
      end else begin : g_staged
         dpx_ctl_t       ctl_q;
         logic [W-1:0]   dat_q;
         always_ff @(posedge clk) begin
            ctl_q <= raw_ctl;
            dat_q <= raw_dat;
         end
         assign cur_ctl = ctl_q;
         assign cur_dat = dat_q;
      end
   endgenerate

   always_ff @(posedge clk) begin
      pclk_d <= cur_ctl.pclk;
   end
endmodule

// File: rtl/dpx_store.sv
module dpx_store #(
   parameter int W = 18
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [W-1:0]  din,
   input  logic          pass,
   input  logic          load,
   output logic [W-1:0]  q
);
   always_ff @(posedge clk) begin
      if (rst)              q <= '0;
      else if (pass | load) q <= din;
   end
endmodule

// File: rtl/dpx_path.sv
module dpx_path
   import dpx_pkg::*;
#(
   parameter int W    = 18,
   parameter int SYNC = 0
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [W-1:0]  src,
   input  dpx_ctl_t      ctl,
   output logic [W-1:0]  dst,
   output logic          drv_n
);
   dpx_ctl_t      c;
   logic [W-1:0]  d;
   logic          pclk_d;
   logic          fall_ok;

   dpx_ctl_in #(.W(W), .SYNC(SYNC)) u_in (
      .clk(clk), .raw_ctl(ctl), .raw_dat(src),
      .cur_ctl(c), .cur_dat(d), .pclk_d(pclk_d)
   );

   assign fall_ok = pclk_d & ~c.pclk & ~c.cke_n;

   dpx_store #(.W(W)) u_st (
      .clk(clk), .rst(rst), .din(d), .pass(c.le), .load(fall_ok), .q(dst)
   );

   always_ff @(posedge clk) begin
      if (rst) drv_n <= 1'b1;
      else     drv_n <= c.en_n;
   end
endmodule

// File: rtl/dual_path_xcvr.sv
module dual_path_xcvr
   import dpx_pkg::*;
#(
   parameter int W    = 18,
   parameter int SYNC = 0
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [W-1:0]  a_in,
   output logic [W-1:0]  a_out,
   output logic          a_drv_n,
   input  logic [W-1:0]  b_in,
   output logic [W-1:0]  b_out,
   output logic          b_drv_n,
   input  logic          ab_en_n,
   input  logic          ab_le,
   input  logic          ab_pclk,
   input  logic          ab_cke_n,
   input  logic          ba_en_n,
   input  logic          ba_le,
   input  logic          ba_pclk,
   input  logic          ba_cke_n
);
   generate
      if (W < 1) begin : g_bad_w
         $error("dual_path_xcvr: W must be at least 1");
      end
      if (SYNC != 0 && SYNC != 1) begin : g_bad_sync
         $error("dual_path_xcvr: SYNC must be 0 or 1");
      end
   endgenerate

   logic [W-1:0] src [DPX_NDIR];
   logic [W-1:0] dst [DPX_NDIR];
   logic         drv [DPX_NDIR];
   dpx_ctl_t     ctl [DPX_NDIR];

   assign src[0] = a_in;
   assign src[1] = b_in;
   assign ctl[0] = '{en_n: ab_en_n, le: ab_le, pclk: ab_pclk, cke_n: ab_cke_n};
   assign ctl[1] = '{en_n: ba_en_n, le: ba_le, pclk: ba_pclk, cke_n: ba_cke_n};

   generate
      for (genvar g = 0; g < DPX_NDIR; g++) begin : g_dir
         dpx_path #(.W(W), .SYNC(SYNC)) u_path (
            .clk(clk), .rst(rst), .src(src[g]), .ctl(ctl[g]),
            .dst(dst[g]), .drv_n(drv[g])
         );
      end
   endgenerate

   assign b_out   = dst[0];
   assign b_drv_n = drv[0];
   assign a_out   = dst[1];
   assign a_drv_n = drv[1];
endmodule

// File: rtl/dpx_checker.sv
module dpx_checker #(
   parameter int W    = 18,
   parameter int SYNC = 0
) (
   input logic          clk,
   input logic          rst,
   input logic [W-1:0]  a_in,
   input logic [W-1:0]  a_out,
   input logic          a_drv_n,
   input logic [W-1:0]  b_in,
   input logic [W-1:0]  b_out,
   input logic          b_drv_n,
   input logic          ab_en_n,
   input logic          ab_le,
   input logic          ab_pclk,
   input logic          ab_cke_n,
   input logic          ba_en_n,
   input logic          ba_le,
   input logic          ba_pclk,
   input logic          ba_cke_n
);
   generate
      if (SYNC == 0) begin : g_chk
         p_reset_ab_r1: assert property (@(posedge clk)
            rst |=> (b_out == '0 && b_drv_n));
         p_reset_ba_r1: assert property (@(posedge clk)
            rst |=> (a_out == '0 && a_drv_n));

         p_pass_ab_r2: assert property (@(posedge clk) disable iff (rst)
            ab_le |=> b_out == $past(a_in));
         p_pass_ba_r2: assert property (@(posedge clk) disable iff (rst)
            ba_le |=> a_out == $past(b_in));

         p_hold_ab_r3: assert property (@(posedge clk) disable iff (rst)
            (!ab_le && !($past(ab_pclk) && !ab_pclk && !ab_cke_n)) |=> $stable(b_out));
         p_hold_ba_r3: assert property (@(posedge clk) disable iff (rst)
            (!ba_le && !($past(ba_pclk) && !ba_pclk && !ba_cke_n)) |=> $stable(a_out));

         p_load_ab_r4: assert property (@(posedge clk) disable iff (rst)
            (!ab_le && $past(ab_pclk) && !ab_pclk && !ab_cke_n) |=> b_out == $past(a_in));
         p_load_ba_r4: assert property (@(posedge clk) disable iff (rst)
            (!ba_le && $past(ba_pclk) && !ba_pclk && !ba_cke_n) |=> a_out == $past(b_in));

         p_drive_ab_r6: assert property (@(posedge clk) disable iff (rst)
            1'b1 |=> b_drv_n == $past(ab_en_n));
         p_drive_ba_r6: assert property (@(posedge clk) disable iff (rst)
            1'b1 |=> a_drv_n == $past(ba_en_n));
      end
   endgenerate
endmodule

bind dual_path_xcvr dpx_checker #(.W(W), .SYNC(SYNC)) u_dpx_chk (
   .clk(clk), .rst(rst), .a_in(a_in), .a_out(a_out), .a_drv_n(a_drv_n),
   .b_in(b_in), .b_out(b_out), .b_drv_n(b_drv_n),
   .ab_en_n(ab_en_n), .ab_le(ab_le), .ab_pclk(ab_pclk), .ab_cke_n(ab_cke_n),
   .ba_en_n(ba_en_n), .ba_le(ba_le), .ba_pclk(ba_pclk), .ba_cke_n(ba_cke_n)
);

// File: tb/dual_path_xcvr_tb_top.sv
module dual_path_xcvr_tb_top;
   localparam int W = 18;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [W-1:0] a_in = '0, b_in = '0, a_out, b_out;
   logic a_drv_n, b_drv_n;
   logic ab_en_n = 1'b1, ab_le = 1'b0, ab_pclk = 1'b0, ab_cke_n = 1'b1;
   logic ba_en_n = 1'b1, ba_le = 1'b0, ba_pclk = 1'b0, ba_cke_n = 1'b1;

   int total = 0;
   int bad = 0;

   logic [W-1:0] e_b = '0, e_a = '0;
   logic e_bdrv = 1'b1, e_adrv = 1'b1;
   logic pv_ab = 1'b0, pv_ba = 1'b0;
   string tag_ab, tag_ba;
   logic conflict;

   always #10 clk = ~clk;

   dual_path_xcvr #(.W(W)) dut_i (
      .clk(clk), .rst(rst), .a_in(a_in), .a_out(a_out), .a_drv_n(a_drv_n),
      .b_in(b_in), .b_out(b_out), .b_drv_n(b_drv_n),
      .ab_en_n(ab_en_n), .ab_le(ab_le), .ab_pclk(ab_pclk), .ab_cke_n(ab_cke_n),
      .ba_en_n(ba_en_n), .ba_le(ba_le), .ba_pclk(ba_pclk), .ba_cke_n(ba_cke_n)
   );

   task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Model of one path from the requirements; returns the tag of the rule applied.
   task automatic model(input logic le, input logic pc, input logic ck_n,
                        input logic [W-1:0] din, inout logic pv,
                        inout logic [W-1:0] e, output string tag);
      if (le) begin
         e = din; tag = "R2";
      end else if (pv && !pc && !ck_n) begin
         e = din; tag = "R4";
      end else if (pv && !pc && ck_n) begin
         tag = "R5";
      end else if (!pv && pc) begin
         tag = "R9";
      end else begin
         tag = "R3";
      end
      pv = pc;
   endtask

   // Advance one system clock; compare all outputs against the model.
   task automatic tick();
      conflict = !ab_en_n && !ba_en_n;
      model(ab_le, ab_pclk, ab_cke_n, a_in, pv_ab, e_b, tag_ab);
      model(ba_le, ba_pclk, ba_cke_n, b_in, pv_ba, e_a, tag_ba);
      e_bdrv = ab_en_n;
      e_adrv = ba_en_n;
      @(posedge clk);
      #5;
      chk("R6 b drive", {{(W-1){1'b0}}, b_drv_n}, {{(W-1){1'b0}}, e_bdrv});
      chk("R6 a drive", {{(W-1){1'b0}}, a_drv_n}, {{(W-1){1'b0}}, e_adrv});
      if (conflict) begin
         $display("NOTE usage conflict: both paths enabled at %0t, data not judged", $time);
      end else begin
         chk({tag_ab, " R8 b data"}, b_out, e_b);
         chk({tag_ba, " R8 a data"}, a_out, e_a);
      end
   endtask

   initial begin
      #(20 * 150000);
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      // R1: reset
      a_in = 18'h2AAAA; b_in = 18'h15555; ab_le = 1'b1; ba_le = 1'b1;
      ab_en_n = 1'b0; ba_en_n = 1'b0;
      repeat (3) @(posedge clk);
      #5;
      @(negedge clk);
      rst = 1'b0;
      ab_le = 1'b0; ba_le = 1'b0; ab_en_n = 1'b1; ba_en_n = 1'b1;
      chk("R1 b data", b_out, '0);
      chk("R1 a data", a_out, '0);
      chk("R1 b drive", {{(W-1){1'b0}}, b_drv_n}, {{(W-1){1'b0}}, 1'b1});
      chk("R1 a drive", {{(W-1){1'b0}}, a_drv_n}, {{(W-1){1'b0}}, 1'b1});
      e_a = '0; e_b = '0; pv_ab = 1'b0; pv_ba = 1'b0;

      // R2 then R7: transparent, then latch enable falls with static clock
      ab_le = 1'b1; a_in = 18'h0F0F0; tick();
      a_in = 18'h12345; tick();
      chk("R2 transparent b", b_out, 18'h12345);
      ab_le = 1'b0; a_in = 18'h3FFFF; tick();
      chk("R7 hold after le fall", b_out, 18'h12345);
      a_in = 18'h00001; tick();
      chk("R7 hold steady", b_out, 18'h12345);

      // R9: rising port clock does not load
      ab_pclk = 1'b1; ab_cke_n = 1'b0; a_in = 18'h0ABCD; tick();
      chk("R9 rising edge ignored", b_out, 18'h12345);
      tick();
      chk("R3 clock held high", b_out, 18'h12345);

      // R4: falling edge loads, with drive disabled (R6)
      ab_en_n = 1'b1; ab_pclk = 1'b0; a_in = 18'h2468A; tick();
      chk("R4 falling edge load while undriven R6", b_out, 18'h2468A);
      a_in = 18'h11111; tick();
      chk("R3 clock held low", b_out, 18'h2468A);

      // R5: clock enable high blocks a falling edge
      ab_pclk = 1'b1; tick();
      ab_cke_n = 1'b1; ab_pclk = 1'b0; a_in = 18'h33333; tick();
      chk("R5 edge blocked", b_out, 18'h2468A);

      // R8: B-to-A activity leaves b_out alone
      ba_le = 1'b1; ba_en_n = 1'b0;
      for (int k = 0; k < 4; k++) begin
         b_in = 18'(k * 18'h01357); ba_pclk = k[0];
         tick();
         chk("R8 b_out untouched", b_out, 18'h2468A);
      end

      // Near-exhaustive sweep over both paths' controls and data
      for (int i = 0; i < 4096; i++) begin
         logic [7:0] c;
         c = 8'(i) ^ 8'(i >> 8);
         {ab_en_n, ab_le, ab_pclk, ab_cke_n} = c[3:0];
         {ba_cke_n, ba_pclk, ba_le, ba_en_n} = c[7:4];
         a_in = 18'(i * 32'h9E37 ^ (i << 5));
         b_in = 18'(i * 32'h7F4B + 32'h155);
         tick();
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule